// File: doc/BRIEF.md
# Selectable-Format Stereo Serial Audio Port

This block is a slave-mode stereo serial audio port with a transmit path and a receive path. Both paths share one externally supplied bit clock and one left/right frame clock. A frame is 64 bit clocks long and holds two 32-bit half-frames. A 2-bit selector picks one of four framings: 24-bit right-justified, 20-bit right-justified, 24-bit left-justified or 24-bit I2S. The chosen framing governs both directions at once. The transmitter serialises parallel left and right samples onto one data line. The receiver rebuilds parallel samples from the incoming data line and marks each finished word with a one-cycle strobe and a channel flag.

The bit clock and frame clock are oversampled by the system clock `clk` through synchronisers, and their edges are detected in that domain. Each bit-clock phase must therefore last at least five system clock cycles. A new selector value is taken up only at a frame boundary, so a frame is never split between two framings. The samples to be sent are captured at that same boundary. Samples are 24 bits wide. In 20-bit mode the transmitter sends the upper 20 bits, and the receiver returns the word left-aligned with zero padding below it.

Top module: `aud_serial_port`

## Requirements
- R1: `fmt_sel` encodes the framing as 2'b00 = 24-bit right-justified, 2'b01 = 20-bit right-justified, 2'b10 = 24-bit left-justified and 2'b11 = 24-bit I2S, and the active framing governs transmit and receive alike.
- R2: Each half-frame is 32 bit clocks long and starts at a frame-clock transition. The left channel occupies the half with the frame clock high, except in I2S, where it occupies the half with the frame clock low.
- R3: Words travel MSB first. In left-justified mode the MSB occupies bit slot 0 of the half-frame, and in I2S it occupies slot 1. Slots after the LSB carry 0.
- R4: In both right-justified modes the LSB occupies slot 31, and every slot before the MSB carries 0. In 20-bit mode the transmitted word is bits 23..4 of the parallel sample.
- R5: `sdata_o` changes only after a falling bit-clock edge, and `sdata_i` is sampled only on a rising bit-clock edge.
- R6: The receiver raises `rx_valid` for exactly one `clk` cycle per channel per frame once the last bit of that channel's word has arrived. `rx_right` is 1 for the right channel. In 20-bit mode `rx_data` holds the 20 received bits in bits 23..4 with bits 3..0 zero.
- R7: A change of `fmt_sel` takes effect only at the start of the next half-frame that is the left half under the framing then active. The transmit samples for the whole frame are captured at that same point.
- R8: While in reset and after reset, `sdata_o` and `rx_valid` are 0 and `rx_data` is zero. No `rx_valid` occurs before the first frame-clock transition after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Framing selector shared by both directions |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External left/right frame clock |
| tx_left | input | 24 | Left sample to transmit |
| tx_right | input | 24 | Right sample to transmit |
| sdata_o | output | 1 | Serial transmit data |
| sdata_i | input | 1 | Serial receive data |
| rx_data | output | 24 | Last received word |
| rx_right | output | 1 | Channel of `rx_data`: 1 = right, 0 = left |
| rx_valid | output | 1 | One-cycle strobe marking a new received word |

## Verification
The collision of interest is a selector update that arrives in the same system cycle as the frame boundary that would adopt it. The bench provokes this by changing `fmt_sel` on the very bit-clock fall where the frame clock turns to the left half. It judges the result by decoding that whole frame, in both directions, in the new framing. A second scenario moves the selector change a few slots into a left half-frame. The bench then expects that frame to stay entirely in the old framing and the following frame to switch.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;

  localparam int WORD_W  = 24;
  localparam int SHORT_W = 20;
  localparam int HALF_W  = 32;
  localparam int SLOT_W  = $clog2(HALF_W);
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int PAD_W   = WORD_W - SHORT_W;

  typedef enum logic [1:0] {
    FMT_RJ24 = 2'b00,
    FMT_RJ20 = 2'b01,
    FMT_LJ24 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;

  // slot that carries the MSB of a word in the given framing
  function automatic int data_first(fmt_e f);
    case (f)
      FMT_RJ24: return HALF_W - WORD_W;
      FMT_RJ20: return HALF_W - SHORT_W;
      FMT_LJ24: return 0;
      default:  return 1;
    endcase
  endfunction

  // number of data slots in a half-frame for the given framing
  function automatic int data_len(fmt_e f);
    return (f == FMT_RJ20) ? SHORT_W : WORD_W;
  endfunction

endpackage

// File: rtl/asp_timing.sv
module asp_timing
  import aud_sp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  fmt_e              fmt_sel,
  output logic              fall_stb,
  output logic              rise_stb,
  output logic              chan_left,
  output logic              frm_start,
  output logic              seen,
  output logic [SLOT_W-1:0] slot,
  output fmt_e              fmt_act
);

  logic [SYNC_STAGES:0]   bck_sr;
  logic [SYNC_STAGES-1:0] lr_sr;
  logic                   lr_lvl, lr_now, lr_chg, left_old;
  logic                   lr_n, seen_n, frm_n;
  logic [SLOT_W-1:0]      slot_n;
  fmt_e                   fmt_n;

  assign fall_stb  = bck_sr[SYNC_STAGES] & ~bck_sr[SYNC_STAGES-1];
  assign rise_stb  = ~bck_sr[SYNC_STAGES] & bck_sr[SYNC_STAGES-1];
  assign lr_now    = lr_sr[SYNC_STAGES-1];
  assign chan_left = (fmt_act == FMT_I2S) ? ~lr_lvl : lr_lvl;

  always_comb begin
    lr_chg   = lr_now ^ lr_lvl;
    left_old = (fmt_act == FMT_I2S) ? ~lr_now : lr_now;
    slot_n   = slot;
    lr_n     = lr_lvl;
    seen_n   = seen;
    fmt_n    = fmt_act;
    frm_n    = 1'b0;
    if (fall_stb) begin
      lr_n   = lr_now;
      seen_n = seen | lr_chg;
      slot_n = lr_chg ? '0 : slot + SLOT_W'(1);
      if (lr_chg && left_old) begin
        frm_n = 1'b1;
        fmt_n = fmt_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_sr    <= '0;
      lr_sr     <= '0;
      lr_lvl    <= 1'b0;
      seen      <= 1'b0;
      slot      <= '0;
      fmt_act   <= FMT_RJ24;
      frm_start <= 1'b0;
    end else begin
      bck_sr    <= {bck_sr[SYNC_STAGES-1:0], bclk_i};
      lr_sr     <= {lr_sr[SYNC_STAGES-2:0], lrclk_i};
      lr_lvl    <= lr_n;
      seen      <= seen_n;
      slot      <= slot_n;
      fmt_act   <= fmt_n;
      frm_start <= frm_n;
    end
  end

endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import aud_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_stb,
  input  logic              frm_start,
  input  logic              chan_left,
  input  logic [SLOT_W-1:0] slot,
  input  fmt_e              fmt_act,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdata_o
);

  logic              upd;
  logic [WORD_W-1:0] l_q, r_q, word;
  logic              hit, sd_n;
  logic [IDX_W-1:0]  idx;
  int                off;

  always_comb begin
    if (frm_start) word = chan_left ? tx_left : tx_right;
    else           word = chan_left ? l_q : r_q;
    off  = int'(slot) - data_first(fmt_act);
    hit  = (off >= 0) && (off < data_len(fmt_act));
    idx  = IDX_W'(WORD_W - 1 - off);
    sd_n = hit ? word[idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd     <= 1'b0;
      l_q     <= '0;
      r_q     <= '0;
      sdata_o <= 1'b0;
    end else begin
      upd <= fall_stb;
      if (upd && frm_start) begin
        l_q <= tx_left;
        r_q <= tx_right;
      end
      if (upd) sdata_o <= sd_n;
    end
  end

endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import aud_sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              seen,
  input  logic              chan_left,
  input  logic [SLOT_W-1:0] slot,
  input  fmt_e              fmt_act,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_right,
  output logic              rx_valid
);

  logic [WORD_W-1:0] sh, sh_n, full, data_n;
  logic              take, done, right_n;
  int                off;

  always_comb begin
    off     = int'(slot) - data_first(fmt_act);
    take    = rise_stb && seen && (off >= 0) && (off < data_len(fmt_act));
    done    = take && (off == data_len(fmt_act) - 1);
    full    = {sh[WORD_W-2:0], sdata_i};
    sh_n    = take ? full : sh;
    data_n  = rx_data;
    right_n = rx_right;
    if (done) begin
      data_n  = (fmt_act == FMT_RJ20) ? (full << PAD_W) : full;
      right_n = ~chan_left;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_data  <= '0;
      rx_right <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      sh       <= sh_n;
      rx_data  <= data_n;
      rx_right <= right_n;
      rx_valid <= done;
    end
  end

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_sp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdata_o,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_right,
  output logic              rx_valid
);

  logic              fall_stb, rise_stb, chan_left, frm_start, seen;
  logic [SLOT_W-1:0] slot;
  fmt_e              fmt_act;

  asp_timing #(.SYNC_STAGES(SYNC_STAGES)) u_tim (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_i    (bclk_i),
    .lrclk_i   (lrclk_i),
    .fmt_sel   (fmt_e'(fmt_sel)),
    .fall_stb  (fall_stb),
    .rise_stb  (rise_stb),
    .chan_left (chan_left),
    .frm_start (frm_start),
    .seen      (seen),
    .slot      (slot),
    .fmt_act   (fmt_act)
  );

  asp_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_stb  (fall_stb),
    .frm_start (frm_start),
    .chan_left (chan_left),
    .slot      (slot),
    .fmt_act   (fmt_act),
    .tx_left   (tx_left),
    .tx_right  (tx_right),
    .sdata_o   (sdata_o)
  );

  asp_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_stb  (rise_stb),
    .seen      (seen),
    .chan_left (chan_left),
    .slot      (slot),
    .fmt_act   (fmt_act),
    .sdata_i   (sdata_i),
    .rx_data   (rx_data),
    .rx_right  (rx_right),
    .rx_valid  (rx_valid)
  );

endmodule

// File: rtl/asp_chk.sv
module asp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fall_stb,
  input logic       rise_stb,
  input logic       frm_start,
  input logic       seen,
  input logic       sdata_o,
  input logic       rx_valid,
  input logic [1:0] fmt_act
);

  // R6
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  rx_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> seen);

  // R7
  fmt_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_act) |-> frm_start);

  // R5
  tx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $past(fall_stb, 2));

  // R5
  rx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise_stb));

endmodule

bind aud_serial_port asp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fall_stb  (fall_stb),
  .rise_stb  (rise_stb),
  .frm_start (frm_start),
  .seen      (seen),
  .sdata_o   (sdata_o),
  .rx_valid  (rx_valid),
  .fmt_act   (fmt_act)
);

// File: tb/aud_serial_port_bench.sv
module aud_serial_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bclk_i = 1'b0;
  logic        lrclk_i = 1'b0;
  logic [23:0] tx_left = '0;
  logic [23:0] tx_right = '0;
  logic        sdata_o;
  logic        sdata_i = 1'b0;
  logic [23:0] rx_data;
  logic        rx_right;
  logic        rx_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int          n_l, n_r;
  logic [23:0] w_l, w_r;

  always #10 clk = ~clk;

  aud_serial_port u_aud_serial_port (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_i(bclk_i),
    .lrclk_i(lrclk_i), .tx_left(tx_left), .tx_right(tx_right),
    .sdata_o(sdata_o), .sdata_i(sdata_i), .rx_data(rx_data),
    .rx_right(rx_right), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_right) begin n_r++; w_r = rx_data; end
      else          begin n_l++; w_l = rx_data; end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // 32-slot half-frame image, bit 31 = slot 0
  function automatic logic [31:0] exp_half(input logic [1:0] f, input logic [23:0] w);
    case (f)
      2'b00:   return {8'b0, w};
      2'b01:   return {12'b0, w[23:4]};
      2'b10:   return {w, 8'b0};
      default: return {1'b0, w, 7'b0};
    endcase
  endfunction

  function automatic logic [23:0] exp_rx(input logic [1:0] f, input logic [23:0] w);
    return (f == 2'b01) ? {w[23:4], 4'b0} : w;
  endfunction

  function automatic string fmt_req(input logic [1:0] f);
    return (f[1] == 1'b0) ? "R1 R2 R4" : "R1 R2 R3";
  endfunction

  // one 64-slot frame encoded with framing enc; optional selector write at slot chg_at
  task automatic do_frame(input logic [1:0] enc, input logic [23:0] lw, input logic [23:0] rw,
                          input bit chk, input int chg_at, input logic [1:0] chg_val);
    logic [31:0] hl, hr;
    logic [63:0] cap;
    int          unstable;
    logic        bitv;
    hl = exp_half(enc, lw);
    hr = exp_half(enc, rw);
    cap = '0;
    unstable = 0;
    tx_left  = lw;
    tx_right = rw;
    n_l = 0;
    n_r = 0;
    for (int b = 0; b < 64; b++) begin
      @(negedge clk);
      bclk_i  = 1'b0;
      lrclk_i = (b < 32) ^ (enc == 2'b11);
      bitv    = (b < 32) ? hl[31-b] : hr[63-b];
      sdata_i = bitv;
      if (b == chg_at) fmt_sel = chg_val;
      repeat (6) @(negedge clk);
      cap[63-b] = sdata_o;
      bclk_i = 1'b1;
      repeat (4) @(negedge clk);
      sdata_i = ~bitv;
      @(negedge clk);
      if (sdata_o != cap[63-b]) unstable++;
    end
    @(negedge clk);
    if (chk) begin
      check(cap[63:32] == hl, fmt_req(enc), "tx left half-frame", cap[63:32], hl);
      check(cap[31:0] == hr, fmt_req(enc), "tx right half-frame", cap[31:0], hr);
      check(unstable == 0, "R5", "tx changed away from falling edge", unstable, 0);
      check(n_l == 1 && n_r == 1, "R6", "valid pulses per channel (l<<16|r)",
            (n_l << 16) | n_r, 32'h0001_0001);
      check(w_l == exp_rx(enc, lw), "R6 R1", "rx left word", {8'b0, w_l}, {8'b0, exp_rx(enc, lw)});
      check(w_r == exp_rx(enc, rw), "R6 R1", "rx right word", {8'b0, w_r}, {8'b0, exp_rx(enc, rw)});
    end
  endtask

  task automatic t_reset();
    int v;
    check(sdata_o == 1'b0, "R8", "sdata_o after reset", {31'b0, sdata_o}, 0);
    check(rx_valid == 1'b0, "R8", "rx_valid after reset", {31'b0, rx_valid}, 0);
    check(rx_data == '0, "R8", "rx_data after reset", {8'b0, rx_data}, 0);
    v = 0;
    sdata_i = 1'b1;
    lrclk_i = 1'b0;
    for (int b = 0; b < 40; b++) begin
      @(negedge clk); bclk_i = 1'b0;
      repeat (6) @(negedge clk);
      bclk_i = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (rx_valid) v++;
      end
    end
    check(v == 0, "R8", "valid before first frame-clock transition", v, 0);
  endtask

  task automatic t_format(input logic [1:0] f);
    fmt_sel = f;
    do_frame(f, 24'h123456, 24'h654321, 0, -1, f);
    do_frame(f, 24'h0F0F0F, 24'hF0F0F0, 0, -1, f);
    do_frame(f, 24'hA5C39E, 24'h5B3C61, 1, -1, f);
    do_frame(f, 24'hFFFFFF, 24'h800001, 1, -1, f);
  endtask

  // R7: selector change inside a left half-frame waits for the next frame
  task automatic t_change_mid();
    fmt_sel = 2'b00;
    do_frame(2'b00, 24'h111111, 24'h222222, 0, -1, 2'b00);
    do_frame(2'b00, 24'h333333, 24'h444444, 0, -1, 2'b00);
    do_frame(2'b00, 24'hC0FFEE, 24'h0BEEF1, 1, 4, 2'b10);
    do_frame(2'b10, 24'hDEC0DE, 24'h7A7A7A, 1, -1, 2'b10);
  endtask

  // R7: selector change arriving together with the boundary applies at once
  task automatic t_coincide();
    do_frame(2'b00, 24'h9ABCDE, 24'h13579B, 1, 0, 2'b00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_format(2'b00);
    t_format(2'b01);
    t_format(2'b10);
    t_format(2'b11);
    t_change_mid();
    t_coincide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule